// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block interprets the write stream of a byte-wide NOR flash emulation. Each bus write arrives as a single-cycle event carrying an address and a data byte. The sequencer follows the multi-write unlock protocol that flash parts expect. It can accept a single-write or three-write reset, an identification mode, a four-write byte program, and a fast sub-mode in which each program needs only two writes. Every read request is answered one cycle later, from one of four sources: the byte array, an identification code, a per-block protection bit, or a status byte.

The array has `BLK_N` equal blocks, and each block holds 2^`OFS_W` bytes. The top address bits pick the block. Each block has a protection flag, driven on `prot_i`. A program into a protected block is dropped without a trace. A program elsewhere ANDs the written byte into the cell. It then holds the sequencer busy for `pgm_len_i` cycles, during which every write is ignored. If a program asked for a 0 bit to become 1, it fails. After a failed program the sequencer stays in a sticky error state until a reset byte arrives.

Command encoding: unlock writes are AAh at 555h, then 55h at 2AAh. A third write at 555h then carries the command: F0h reset, 90h identify, A0h program, 20h fast sub-mode. Unlock address compares use the low 11 address bits.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, busy_o is 0, every array byte reads FFh, and a read returns array data one cycle after rd_en_i.
- R2: A write that does not continue a valid sequence sends the sequencer to read mode, so a 90h at 555h after a broken unlock leaves reads returning array data.
- R3: A single F0h write at any address, or AAh@555h, 55h@2AAh, F0h@555h, leaves identify mode for read mode.
- R4: Identify mode is entered with AAh@555h, 55h@2AAh, 90h@555h and lasts across any number of reads. In it, a read with address bits [1:0]=00 returns 20h, 01 returns E3h, and 11 returns 00h.
- R5: In identify mode, a read with bits [1:0]=10 returns 01h if the block named by the top address bits is protected, and 00h otherwise.
- R6: AAh@555h, 55h@2AAh, A0h@555h, then a write of (A, D) to an unprotected block stores old AND D at A.
- R7: A program whose target lies in a protected block starts no busy period, leaves the cell unchanged and raises no error.
- R8: A program keeps busy_o high for max(pgm_len_i, 1) cycles. Writes during that time are ignored. Reads return status: bit 7 is the inverse of bit 7 of the programmed byte, bit 5 is 0, and bit 6 toggles on each status read.
- R9: A program whose data has a 1 where the old cell holds 0 fails. The array still takes old AND D. After the busy time, reads return status with bit 5 set, and only F0h clears it.
- R10: AAh@555h, 55h@2AAh, 20h@555h enters the fast sub-mode. There, reads return array data, A0h followed by (A, D) programs as in R6, and any other single write is ignored.
- R11: In the fast sub-mode, 90h followed by 00h returns to read mode. 90h followed by any other byte stays in the sub-mode.
- R12: F0h after a failed program in the fast sub-mode clears the error and returns to the fast sub-mode, not to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_i | input | BLK_N | Per-block protection flags |
| pgm_len_i | input | CNT_W | Busy length of one program, in cycles |
| wr_en_i | input | 1 | Bus write event |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Bus read request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read result, valid the cycle after rd_en_i |
| busy_o | output | 1 | Program in progress |

## Verification
The bench checks that a broken unlock falls back to read mode. A design that kept partial sequence state would instead answer with identification codes. Commands are written during a long busy period; a sequencer that listened to them would come out of busy in identify mode. The bench drives a program into a protected block and one that tries to set a cleared bit. A design that mishandled these would start a busy period, change the cell, skip the sticky error, or leave the fast sub-mode on reset. The randomly chosen programs compare the busy length, the AND result and the error outcome against a bench model of the array.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
   localparam int CMD_AW = 11;
   localparam logic [CMD_AW-1:0] K_UL_A1 = 11'h555;
   localparam logic [CMD_AW-1:0] K_UL_A2 = 11'h2AA;
   localparam logic [7:0] K_UL_D1  = 8'hAA;
   localparam logic [7:0] K_UL_D2  = 8'h55;
   localparam logic [7:0] K_RESET  = 8'hF0;
   localparam logic [7:0] K_IDENT  = 8'h90;
   localparam logic [7:0] K_PROG   = 8'hA0;
   localparam logic [7:0] K_FAST   = 8'h20;
   localparam logic [7:0] K_FEXIT  = 8'h00;
   localparam logic [7:0] ID_MFR   = 8'h20;
   localparam logic [7:0] ID_DEV   = 8'hE3;

   typedef enum logic [3:0] {
      ST_READ, ST_UL1, ST_UL2, ST_IDENT, ST_PGM,
      ST_FAST, ST_FAST_PG, ST_FAST_EX, ST_BUSY, ST_ERR
   } seq_st_t;
endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= (len == '0) ? CNT_W'(1) : len;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign done = (cnt_q == CNT_W'(1));

   AST_TMR_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> cnt_q == '0); // R8
endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array #(
   parameter int BLK_N = 8,
   parameter int OFS_W = 8,
   parameter logic [7:0] ERASED = 8'hFF
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [$clog2(BLK_N)+OFS_W-1:0] waddr,
   input  logic [7:0]                   wdata,
   output logic [7:0]                   wold,
   input  logic [$clog2(BLK_N)+OFS_W-1:0] raddr,
   output logic [7:0]                   rdata
);
   localparam int BLK_W  = $clog2(BLK_N);
   localparam int DEPTH  = 1 << OFS_W;

   logic [BLK_W-1:0] w_blk, r_blk;
   logic [OFS_W-1:0] w_ofs, r_ofs;
   logic [7:0]       rd_b  [BLK_N];
   logic [7:0]       old_b [BLK_N];

   assign w_blk = waddr[BLK_W+OFS_W-1 -: BLK_W];
   assign r_blk = raddr[BLK_W+OFS_W-1 -: BLK_W];
   assign w_ofs = waddr[OFS_W-1:0];
   assign r_ofs = raddr[OFS_W-1:0];

   for (genvar b = 0; b < BLK_N; b++) begin : g_blk
      logic [7:0] cells [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
         end else if (we && w_blk == BLK_W'(b)) begin
            cells[w_ofs] <= cells[w_ofs] & wdata;
         end
      end
      assign rd_b[b]  = cells[r_ofs];
      assign old_b[b] = cells[w_ofs];
   end

   assign rdata = rd_b[r_blk];
   assign wold  = old_b[w_blk];
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
   import nor_seq_pkg::*;
#(
   parameter int BLK_N  = 8,
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [BLK_N-1:0]  prot,
   input  logic [7:0]        old_byte,
   input  logic              tmr_done,
   output logic              go,
   output seq_st_t           st
);
   localparam int BLK_W = $clog2(BLK_N);

   seq_st_t st_q, nxt;
   logic    fast_q, fast_n, err_q;
   logic    hit1, hit2, at_a1, wprot;

   assign at_a1 = (wr_addr[CMD_AW-1:0] == K_UL_A1);
   assign hit1  = at_a1 && (wr_data == K_UL_D1);
   assign hit2  = (wr_addr[CMD_AW-1:0] == K_UL_A2) && (wr_data == K_UL_D2);
   assign wprot = prot[wr_addr[ADDR_W-1 -: BLK_W]];

   always_comb begin
      nxt    = st_q;
      fast_n = fast_q;
      go     = 1'b0;
      unique case (st_q)
         ST_READ, ST_IDENT: if (wr_en) begin
            if (wr_data == K_RESET) nxt = ST_READ;
            else if (hit1)          nxt = ST_UL1;
            else                    nxt = ST_READ;
         end
         ST_UL1: if (wr_en) nxt = hit2 ? ST_UL2 : ST_READ;
         ST_UL2: if (wr_en) begin
            nxt = ST_READ;
            if (at_a1) begin
               unique case (wr_data)
                  K_IDENT: nxt = ST_IDENT;
                  K_PROG:  nxt = ST_PGM;
                  K_FAST:  begin nxt = ST_FAST; fast_n = 1'b1; end
                  default: nxt = ST_READ;
               endcase
            end
         end
         ST_PGM: if (wr_en) begin
            if (wprot) nxt = ST_READ;
            else begin nxt = ST_BUSY; go = 1'b1; end
         end
         ST_FAST: if (wr_en) begin
            if (wr_data == K_PROG)       nxt = ST_FAST_PG;
            else if (wr_data == K_IDENT) nxt = ST_FAST_EX;
         end
         ST_FAST_PG: if (wr_en) begin
            if (wprot) nxt = ST_FAST;
            else begin nxt = ST_BUSY; go = 1'b1; end
         end
         ST_FAST_EX: if (wr_en) begin
            if (wr_data == K_FEXIT) begin nxt = ST_READ; fast_n = 1'b0; end
            else nxt = ST_FAST;
         end
         ST_BUSY: if (tmr_done) nxt = err_q ? ST_ERR : (fast_q ? ST_FAST : ST_READ);
         ST_ERR: if (wr_en && wr_data == K_RESET) nxt = fast_q ? ST_FAST : ST_READ;
         default: nxt = ST_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_READ;
         fast_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= nxt;
         fast_q <= fast_n;
         if (go) err_q <= |(wr_data & ~old_byte);
      end
   end

   assign st = st_q;

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BUSY && !tmr_done) |=> st_q == ST_BUSY); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ERR && !(wr_en && wr_data == K_RESET)) |=> st_q == ST_ERR); // R9
   AST_FAST_CONFINED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FAST && wr_en && wr_data != K_PROG && wr_data != K_IDENT) |=> st_q == ST_FAST); // R10
   AST_FAST_ERR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ERR && fast_q && wr_en && wr_data == K_RESET) |=> st_q == ST_FAST); // R12
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_seq_pkg::*;
#(
   parameter int BLK_N  = 8,
   parameter int OFS_W  = 8,
   parameter int CNT_W  = 8,
   localparam int BLK_W  = $clog2(BLK_N),
   localparam int ADDR_W = BLK_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BLK_N-1:0]  prot_i,
   input  logic [CNT_W-1:0]  pgm_len_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o,
   output logic              busy_o
);
   if (ADDR_W < CMD_AW) begin : g_chk_addr
      $error("address too narrow for unlock addresses");
   end
   if ((1 << BLK_W) != BLK_N || BLK_N < 2) begin : g_chk_blk
      $error("BLK_N must be a power of two, at least 2");
   end
   if (CNT_W < 1) begin : g_chk_cnt
      $error("CNT_W must be at least 1");
   end

   seq_st_t    st;
   logic       go, tmr_done, stat_mode;
   logic       pd7_q, tog_q;
   logic [7:0] old_byte, arr_rd, id_byte, stat_byte, rd_nxt;

   nor_cmd_fsm #(.BLK_N(BLK_N), .ADDR_W(ADDR_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
      .wr_data(wr_data_i), .prot(prot_i), .old_byte(old_byte),
      .tmr_done(tmr_done), .go(go), .st(st));

   nor_busy_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(go), .len(pgm_len_i), .done(tmr_done));

   nor_byte_array #(.BLK_N(BLK_N), .OFS_W(OFS_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .we(go), .waddr(wr_addr_i), .wdata(wr_data_i),
      .wold(old_byte), .raddr(rd_addr_i), .rdata(arr_rd));

   assign stat_mode = (st == ST_BUSY) || (st == ST_ERR);
   assign stat_byte = {~pd7_q, tog_q, st == ST_ERR, 5'b0};

   always_comb begin
      unique case (rd_addr_i[1:0])
         2'b00:   id_byte = ID_MFR;
         2'b01:   id_byte = ID_DEV;
         2'b10:   id_byte = {7'b0, prot_i[rd_addr_i[ADDR_W-1 -: BLK_W]]};
         default: id_byte = 8'h00;
      endcase
      if (stat_mode)            rd_nxt = stat_byte;
      else if (st == ST_IDENT)  rd_nxt = id_byte;
      else                      rd_nxt = arr_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_o <= 8'h00;
         pd7_q     <= 1'b1;
         tog_q     <= 1'b0;
      end else begin
         if (rd_en_i) rd_data_o <= rd_nxt;
         if (go) pd7_q <= wr_data_i[7];
         if (rd_en_i && stat_mode) tog_q <= ~tog_q;
      end
   end

   assign busy_o = (st == ST_BUSY);

   AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && st == ST_BUSY) |=> rd_data_o[5] == 1'b0); // R8
   AST_PROT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (st == ST_PGM || st == ST_FAST_PG) && prot_i[wr_addr_i[ADDR_W-1 -: BLK_W]])
      |=> !busy_o); // R7
   AST_IDENT_DEV: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && st == ST_IDENT && rd_addr_i[1:0] == 2'b01) |=> rd_data_o == ID_DEV); // R4
endmodule

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/1ps
module sim_nor_cmd_seq;
   localparam int AW = 11;
   logic clk = 1'b0, rst_n = 1'b0;
   logic [7:0] prot_i = 8'h00;
   logic [7:0] pgm_len_i = 8'd3;
   logic wr_en_i = 1'b0, rd_en_i = 1'b0;
   logic [AW-1:0] wr_addr_i = '0, rd_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic [7:0] rd_data_o;
   logic busy_o;
   int n_chk = 0, n_fail = 0;
   logic [7:0] model [2048];

   always #2.5 clk = ~clk;

   nor_cmd_seq u0 (.clk(clk), .rst_n(rst_n), .prot_i(prot_i), .pgm_len_i(pgm_len_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk); wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk); wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
      @(negedge clk); rd_en_i = 1'b1; rd_addr_i = a;
      @(negedge clk); rd_en_i = 1'b0; v = rd_data_o;
   endtask

   task automatic unlock(input logic [7:0] cmd);
      wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, cmd);
   endtask

   function automatic logic is_prot(input logic [AW-1:0] a);
      return prot_i[a[10:8]];
   endfunction

   // issue a program (full or fast form), then check busy length, error, result
   task automatic prog(input logic [AW-1:0] a, input logic [7:0] d, input logic fast,
                       input logic [7:0] len, input string req);
      int cnt;
      logic err;
      logic [7:0] v;
      pgm_len_i = len;
      if (fast) wr(11'h0, 8'hA0); else unlock(8'hA0);
      err = |(d & ~model[a]);
      wr(a, d);
      cnt = 0;
      while (busy_o) begin cnt++; @(negedge clk); end
      if (is_prot(a)) begin
         check({req, " R7 no busy"}, 8'(cnt), 8'd0);
      end else begin
         check({req, " R8 busy len"}, 8'(cnt), (len == 0) ? 8'd1 : len);
         model[a] = model[a] & d;
         if (err) begin
            rd(a, v);
            check({req, " R9 err status"}, v & 8'hA0, {~d[7], 7'b0} | 8'h20);
            wr(11'h0, 8'hF0);
         end
      end
      rd(a, v);
      check({req, " R6 cell"}, v, model[a]);
   endtask

   initial begin : wd
      repeat (150000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [7:0] v, v2;
      logic [AW-1:0] a;
      void'($urandom(32'd1234));
      prot_i = ((8'($urandom) | 8'h80) & 8'hFE);
      for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy after reset", {7'b0, busy_o}, 8'h00);
      rd(11'h000, v); check("R1 erased read", v, 8'hFF);
      rd(11'h7FD, v); check("R1 erased read high", v, 8'hFF);
      // R4 identify
      unlock(8'h90);
      rd(11'h3A0, v); check("R4 mfr code", v, 8'h20);
      rd(11'h051, v); check("R4 dev code", v, 8'hE3);
      rd(11'h600, v); check("R4 mode persists", v, 8'h20);
      rd(11'h003, v); check("R4 code 11", v, 8'h00);
      // R5 protection status per block
      for (int b = 0; b < 8; b++) begin
         rd({b[2:0], 8'h02}, v); check("R5 prot status", v, {7'b0, prot_i[b]});
      end
      // R3 single-write reset
      wr(11'h123, 8'hF0);
      rd(11'h000, v); check("R3 single reset", v, 8'hFF);
      // R3 three-write reset
      unlock(8'h90);
      rd(11'h000, v); check("R3 re-enter ident", v, 8'h20);
      unlock(8'hF0);
      rd(11'h000, v); check("R3 three-write reset", v, 8'hFF);
      // R2 broken sequences
      wr(11'h555, 8'hAA); wr(11'h2AB, 8'h55); wr(11'h555, 8'h90);
      rd(11'h000, v); check("R2 bad second address", v, 8'hFF);
      unlock(8'h77); wr(11'h555, 8'h90);
      rd(11'h001, v); check("R2 bad command byte", v, 8'hFF);
      // R6 / R8 directed programs
      prog(11'h010, 8'hF3, 1'b0, 8'd5, "dir1");
      prog(11'h010, 8'h33, 1'b0, 8'd0, "dir2");
      // R8 status while busy, writes ignored
      pgm_len_i = 8'd40;
      unlock(8'hA0);
      wr(11'h020, 8'h5A);
      model[11'h020] = 8'h5A;
      rd(11'h020, v);  rd(11'h020, v2);
      check("R8 status bit7", v & 8'h80, 8'h80);
      check("R8 status bit5", v & 8'h20, 8'h00);
      check("R8 toggle", (v ^ v2) & 8'h40, 8'h40);
      unlock(8'h90);
      check("R8 still busy", {7'b0, busy_o}, 8'h01);
      while (busy_o) @(negedge clk);
      rd(11'h020, v); check("R8 writes ignored while busy", v, 8'h5A);
      // R7 protected block
      prog(11'h744, 8'h00, 1'b0, 8'd4, "dir-prot");
      // R9 sticky error
      prog(11'h030, 8'h00, 1'b0, 8'd2, "dir3");
      pgm_len_i = 8'd2;
      unlock(8'hA0); wr(11'h030, 8'h0F);
      while (busy_o) @(negedge clk);
      rd(11'h030, v); check("R9 error flag", v & 8'hA0, 8'hA0);
      wr(11'h555, 8'hAA); wr(11'h000, 8'h33);
      rd(11'h030, v); check("R9 error sticky", v & 8'h20, 8'h20);
      wr(11'h000, 8'hF0);
      rd(11'h030, v); check("R9 cleared cell", v, 8'h00);
      // R10 fast sub-mode
      unlock(8'h20);
      rd(11'h010, v); check("R10 array read", v, model[11'h010]);
      wr(11'h000, 8'h33);
      prog(11'h041, 8'hC6, 1'b1, 8'd3, "R10 fast");
      // R11 exit with wrong byte stays
      wr(11'h000, 8'h90); wr(11'h000, 8'h11);
      prog(11'h042, 8'h81, 1'b1, 8'd2, "R11 stay");
      // R12 error in fast mode keeps fast mode
      pgm_len_i = 8'd1;
      wr(11'h000, 8'hA0); wr(11'h041, 8'hFF);
      model[11'h041] = model[11'h041] & 8'hFF;
      while (busy_o) @(negedge clk);
      rd(11'h041, v); check("R12 error flag", v & 8'h20, 8'h20);
      wr(11'h000, 8'hF0);
      prog(11'h043, 8'h7E, 1'b1, 8'd2, "R12 back in fast");
      // R11 proper exit
      wr(11'h000, 8'h90); wr(11'h000, 8'h00);
      wr(11'h000, 8'hA0); wr(11'h044, 8'h00);
      rd(11'h044, v); check("R11 exited fast mode", v, 8'hFF);
      // random programs
      for (int k = 0; k < 150; k++) begin
         a = AW'($urandom);
         if (a[1:0] == 2'b00) a[7:0] = 8'h80 | a[7:0];
         prog(a, 8'($urandom), 1'b0, 8'($urandom % 8), "rnd R6");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule